// File: doc/BRIEF.md
# Masked Multi-Lane Serial Window Matcher

This block watches several bit-serial streams at once. Each lane keeps a sliding window of the most recent `LANE_W` bits it has received. On every rising data clock edge, a new bit enters the window and the oldest bit leaves on the lane's serial output. Each lane also holds a reference word and a don't-care word of the same length. After every shift, the lane reports whether the window equals the reference word, skipping the positions that the don't-care word marks.

The reference and don't-care words are not written through a separate port. They are taken as snapshots of the lane windows. The user first shifts the desired word in serially. A rising edge on the pattern strobe then copies every lane's window into its reference register, and a rising edge on the mask strobe copies every lane's window into its don't-care register.

The lanes can run side by side, so that the inputs form a `LANES`-bit word stream. Alternatively, one lane's serial output can feed another lane's input, or another instance, to build a deeper serial pattern. The per-lane match flags are active low and are updated on the falling clock edge. A single active-low flag reports that at least one lane matched.

Top module: `masked_window_matcher`

## Requirements
- R1: A synchronous active-high `rst` clears every window, reference and don't-care bit. While reset is held and right after it is released, `serOut`, `laneMissN` and `anyMatchN` all read 0. A cleared lane counts as a match, because its empty window equals its empty reference.
- R2: Each lane samples `serIn[i]` on the rising clock edge, at the low end of its window. The bit then appears on `serOut[i]` after the `LANE_W`-th rising edge, counting the capturing edge as the first. A downstream register therefore receives it exactly `LANE_W` edges after this lane did.
- R3: When `patLoad` reads 1 at a rising edge after reading 0 at the previous edge, every lane copies its window into its reference register. The copy takes the window as it stood before that edge's shift. Keeping `patLoad` high for more cycles does not capture again.
- R4: `maskLoad` follows the same rising-edge rule as `patLoad`, but it loads the don't-care registers. A don't-care bit of 1 excludes that window position from the comparison.
- R5: `laneMissN[i]` is 0 exactly when every window bit whose don't-care bit is 0 equals its reference bit. Otherwise it is 1.
- R6: `laneMissN` changes only on the falling clock edge. The value it takes there reflects the window, reference and don't-care contents left by the preceding rising edge.
- R7: `anyMatchN` is 0 when at least one bit of `laneMissN` is 0, and it is 1 only when every lane reports a miss.
- R8: When `serOut[0]` is fed back into `serIn[1]`, a bit captured by lane 0 reaches `serOut[1]` after the `2*LANE_W`-th rising edge, counting lane 0's capturing edge as the first.
- R9: In a freshly cleared lane, shifting in a single 1 raises that lane's `laneMissN` at the next falling edge. The other lanes keep reporting a match.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Data clock; shifts on the rising edge, presents compare flags on the falling edge |
| rst | input | 1 | Synchronous active-high clear of all lane storage and compare flags |
| serIn | input | LANES | One serial input bit per lane |
| patLoad | input | 1 | Strobe; a rising edge copies the windows into the reference registers |
| maskLoad | input | 1 | Strobe; a rising edge copies the windows into the don't-care registers |
| serOut | output | LANES | Oldest window bit of each lane, for chaining |
| laneMissN | output | LANES | Per-lane compare flag, 0 on a masked match |
| anyMatchN | output | 1 | 0 when any lane currently matches |

## Verification
The bound checker watches the following on every cycle:
- the one-step window shift of each lane;
- the one-shot snapshot into the reference and don't-care registers on a strobe edge, and their stability at all other edges;
- the falling-edge transfer of the comparison into `laneMissN`;
- the rule that a fully masked lane always reports a match;
- the consistency of `anyMatchN` with the per-lane flags.

Only the bench scenarios can show the end-to-end properties:
- the full `LANE_W`-edge serial latency;
- the `2*LANE_W` latency of a chained pair of lanes;
- a replayed word stream producing a match after a held-high strobe;
- the cleared state after a reset in the middle of a run.

// File: rtl/pm_pkg.sv
`timescale 1ns/1ps
package pm_pkg;
  // Strobes the control side hands to the lane storage each cycle
  typedef struct packed {
    logic capPattern;
    logic capMask;
  } pmStrobe_t;
endpackage

// File: rtl/pm_lane.sv
`timescale 1ns/1ps
module pm_lane #(
  parameter int W = 70
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         bitIn,
  input  pm_pkg::pmStrobe_t strobe,
  output logic         bitOut,
  output logic [W-1:0] window,
  output logic [W-1:0] refWord,
  output logic [W-1:0] careMask,
  output logic         mismatch
);
  logic [W-1:0] bitMiss;

  always_ff @(posedge clk) begin
    if (rst) begin
      window   <= '0;
      refWord  <= '0;
      careMask <= '0;
    end else begin
      // snapshots see the window before this edge's shift
      if (strobe.capPattern) refWord  <= window;
      if (strobe.capMask)    careMask <= window;
      window <= {window[W-2:0], bitIn};
    end
  end

  // one comparison cell per window position
  for (genvar b = 0; b < W; b++) begin : g_cell
    assign bitMiss[b] = (window[b] ^ refWord[b]) & ~careMask[b];
  end

  assign mismatch = |bitMiss;
  assign bitOut   = window[W-1];
endmodule

// File: rtl/pm_datapath.sv
`timescale 1ns/1ps
module pm_datapath #(
  parameter int W = 70,
  parameter int L = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [L-1:0]     serIn,
  input  pm_pkg::pmStrobe_t strobe,
  output logic [L-1:0]     serOut,
  output logic [L-1:0]     laneMismatch,
  output logic [L*W-1:0]   shFlat,
  output logic [L*W-1:0]   patFlat,
  output logic [L*W-1:0]   maskFlat
);
  for (genvar i = 0; i < L; i++) begin : g_lane
    pm_lane #(.W(W)) lane_i (
      .clk      (clk),
      .rst      (rst),
      .bitIn    (serIn[i]),
      .strobe   (strobe),
      .bitOut   (serOut[i]),
      .window   (shFlat[i*W +: W]),
      .refWord  (patFlat[i*W +: W]),
      .careMask (maskFlat[i*W +: W]),
      .mismatch (laneMismatch[i])
    );
  end
endmodule

// File: rtl/pm_ctrl.sv
`timescale 1ns/1ps
module pm_ctrl #(
  parameter int L = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             patLoad,
  input  logic             maskLoad,
  input  logic [L-1:0]     laneMismatch,
  output pm_pkg::pmStrobe_t strobe,
  output logic [L-1:0]     laneMissN,
  output logic             anyMatchN
);
  logic patLoadQ;
  logic maskLoadQ;

  // previous strobe levels, tracked through reset as well
  always_ff @(posedge clk) begin
    patLoadQ  <= patLoad;
    maskLoadQ <= maskLoad;
  end

  always_comb begin
    strobe.capPattern = patLoad  & ~patLoadQ;
    strobe.capMask    = maskLoad & ~maskLoadQ;
  end

  // compare flags settle half a cycle after the shift
  always_ff @(negedge clk) begin
    if (rst) laneMissN <= '0;
    else     laneMissN <= laneMismatch;
  end

  assign anyMatchN = &laneMissN;
endmodule

// File: rtl/masked_window_matcher.sv
`timescale 1ns/1ps
module masked_window_matcher #(
  parameter int LANE_W = 70,
  parameter int LANES  = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] serIn,
  input  logic             patLoad,
  input  logic             maskLoad,
  output logic [LANES-1:0] serOut,
  output logic [LANES-1:0] laneMissN,
  output logic             anyMatchN
);
  localparam int FLAT_W = LANES * LANE_W;

  pm_pkg::pmStrobe_t strobe;
  logic [LANES-1:0]  laneMismatch;
  logic [FLAT_W-1:0] shFlat;
  logic [FLAT_W-1:0] patFlat;
  logic [FLAT_W-1:0] maskFlat;

  pm_ctrl #(.L(LANES)) ctrl_i (
    .clk          (clk),
    .rst          (rst),
    .patLoad      (patLoad),
    .maskLoad     (maskLoad),
    .laneMismatch (laneMismatch),
    .strobe       (strobe),
    .laneMissN    (laneMissN),
    .anyMatchN    (anyMatchN)
  );

  pm_datapath #(.W(LANE_W), .L(LANES)) dp_i (
    .clk          (clk),
    .rst          (rst),
    .serIn        (serIn),
    .strobe       (strobe),
    .serOut       (serOut),
    .laneMismatch (laneMismatch),
    .shFlat       (shFlat),
    .patFlat      (patFlat),
    .maskFlat     (maskFlat)
  );
endmodule

// File: rtl/pm_checker.sv
`timescale 1ns/1ps
module pm_checker #(
  parameter int W = 70,
  parameter int L = 7
) (
  input logic           clk,
  input logic           rst,
  input logic [L-1:0]   serIn,
  input logic           patLoad,
  input logic           maskLoad,
  input logic [L-1:0]   laneMissN,
  input logic           anyMatchN,
  input logic [L-1:0]   laneMismatch,
  input logic [L*W-1:0] shFlat,
  input logic [L*W-1:0] patFlat,
  input logic [L*W-1:0] maskFlat
);
  for (genvar i = 0; i < L; i++) begin : g_lane_chk
    // R2: window moves one place and takes the sampled input bit
    a_r2_shift_step: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> shFlat[i*W +: W] == {$past(shFlat[i*W +: W-1]), $past(serIn[i])});

    // R4: a lane whose don't-care word is all ones always reports a match
    a_r4_full_mask_match: assert property (@(negedge clk) disable iff (rst)
      (&maskFlat[i*W +: W]) |=> !laneMissN[i]);
  end

  // R3: rising strobe snapshots the pre-shift windows
  a_r3_pat_capture: assert property (@(posedge clk) disable iff (rst)
    (patLoad && !$past(patLoad)) |=> patFlat == $past(shFlat));

  // R3: without a rising strobe the reference words hold
  a_r3_pat_hold: assert property (@(posedge clk) disable iff (rst)
    !(patLoad && !$past(patLoad)) |=> $stable(patFlat));

  // R4: same rule for the don't-care words
  a_r4_mask_capture: assert property (@(posedge clk) disable iff (rst)
    (maskLoad && !$past(maskLoad)) |=> maskFlat == $past(shFlat));

  a_r4_mask_hold: assert property (@(posedge clk) disable iff (rst)
    !(maskLoad && !$past(maskLoad)) |=> $stable(maskFlat));

  // R6: flags take the comparison seen at the previous falling edge
  a_r6_neg_capture: assert property (@(negedge clk) disable iff (rst)
    1'b1 |=> laneMissN == $past(laneMismatch));

  // R7: combined flag against the per-lane flags
  a_r7_any_low: assert property (@(posedge clk) disable iff (rst)
    ($countones(laneMissN) < L) |-> !anyMatchN);

  a_r7_any_high: assert property (@(posedge clk) disable iff (rst)
    ($countones(laneMissN) == L) |-> anyMatchN);
endmodule

bind masked_window_matcher pm_checker #(.W(LANE_W), .L(LANES)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .serIn        (serIn),
  .patLoad      (patLoad),
  .maskLoad     (maskLoad),
  .laneMissN    (laneMissN),
  .anyMatchN    (anyMatchN),
  .laneMismatch (laneMismatch),
  .shFlat       (shFlat),
  .patFlat      (patFlat),
  .maskFlat     (maskFlat)
);

// File: tb/masked_window_matcher_tb_top.sv
`timescale 1ns/1ps
module masked_window_matcher_tb_top;
  localparam int W = 70;
  localparam int L = 7;
  localparam int WATCHDOG_CYCLES = 200000;

  logic         clk = 1'b0;
  logic         rst;
  logic [L-1:0] serIn;
  logic         patLoad;
  logic         maskLoad;
  logic [L-1:0] serOut;
  logic [L-1:0] laneMissN;
  logic         anyMatchN;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  masked_window_matcher #(.LANE_W(W), .LANES(L)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .serIn     (serIn),
    .patLoad   (patLoad),
    .maskLoad  (maskLoad),
    .serOut    (serOut),
    .laneMissN (laneMissN),
    .anyMatchN (anyMatchN)
  );

  // behavioural model built from the requirements
  logic [W-1:0] mSh   [L];
  logic [W-1:0] mPat  [L];
  logic [W-1:0] mMask [L];
  logic prevPl;
  logic prevMl;

  typedef struct {
    logic [L-1:0] so;
    logic [L-1:0] miss;
    logic         any;
    string        req;
  } exp_t;

  exp_t sbq[$];

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [L-1:0] word(input int j);
    return L'((j * 73 + (j >> 3) * 29 + 5) ^ (j * j));
  endfunction

  // driver: apply one cycle of stimulus and queue the expected outputs
  task automatic step(input logic [L-1:0] inBits, input logic pl,
                      input logic ml, input string req);
    exp_t e;
    serIn    = inBits;
    patLoad  = pl;
    maskLoad = ml;
    @(posedge clk);
    for (int i = 0; i < L; i++) begin
      if (pl && !prevPl) mPat[i]  = mSh[i];
      if (ml && !prevMl) mMask[i] = mSh[i];
      mSh[i] = {mSh[i][W-2:0], inBits[i]};
    end
    prevPl = pl;
    prevMl = ml;
    for (int i = 0; i < L; i++) begin
      e.so[i]   = mSh[i][W-1];
      e.miss[i] = |((mSh[i] ^ mPat[i]) & ~mMask[i]);
    end
    e.any = &e.miss;
    e.req = req;
    sbq.push_back(e);
    #1;
  endtask

  // monitor: compare after the falling-edge update of each cycle
  initial begin
    forever begin
      @(posedge clk);
      #4;
      while (sbq.size() > 0) begin
        exp_t e;
        e = sbq.pop_front();
        chk(e.req, int'(laneMissN), int'(e.miss));
        chk("R2",  int'(serOut),    int'(e.so));
        chk("R7",  int'(anyMatchN), int'(e.any));
      end
    end
  end

  task automatic doReset();
    wait (sbq.size() == 0);
    rst = 1'b1; serIn = '0; patLoad = 1'b0; maskLoad = 1'b0;
    repeat (3) @(posedge clk);
    for (int i = 0; i < L; i++) begin
      mSh[i] = '0; mPat[i] = '0; mMask[i] = '0;
    end
    prevPl = 1'b0;
    prevMl = 1'b0;
    #1 rst = 1'b0;
    chk("R1", int'(serOut),    0);
    chk("R1", int'(laneMissN), 0);
    chk("R1", int'(anyMatchN), 0);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * WATCHDOG_CYCLES);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish();
  end

  initial begin
    int cnt;
    doReset();

    // R9 / R6: single 1 into lane 2; flag moves only at the falling edge
    step(L'(1) << 2, 1'b0, 1'b0, "R9");
    #1 chk("R6", int'(laneMissN), 0);
    #2 chk("R9", int'(laneMissN), 32'h4);

    // R2: count rising edges until the marker leaves lane 2
    cnt = 1;
    while (serOut[2] == 1'b0 && cnt < 3 * W) begin
      step('0, 1'b0, 1'b0, "R9");
      cnt++;
    end
    chk("R2", cnt, W);
    step('0, 1'b0, 1'b0, "R5");

    // R3 / R5: word stream, snapshot, held strobe, replay
    for (int j = 0; j < W; j++) step(word(j), 1'b0, 1'b0, "R5");
    step(word(W), 1'b1, 1'b0, "R3");
    for (int k = 0; k < 4; k++) step(word(W + 1 + k), 1'b1, 1'b0, "R3");
    step(word(W + 7), 1'b0, 1'b0, "R3");
    for (int j = 0; j < W; j++) step(word(j), 1'b0, 1'b0, "R5");
    #2;
    chk("R5", int'(laneMissN), 0);
    chk("R5", int'(anyMatchN), 0);
    step(word(3) ^ L'(7'h55), 1'b0, 1'b0, "R5");

    // R4: lane 0 fully masked, lane 3 masked on alternate positions
    for (int j = 0; j < W; j++) begin
      logic [L-1:0] m;
      m = '0;
      m[0] = 1'b1;
      m[3] = j[0];
      step(m, 1'b0, 1'b0, "R4");
    end
    step(word(5), 1'b0, 1'b1, "R4");
    for (int j = 0; j < 2 * W; j++) step(word(j * 5 + 1), 1'b0, 1'b0, "R4");
    #2;
    chk("R4", int'(laneMissN[0]), 0);
    chk("R4", int'(anyMatchN), 0);

    // R8: lane 0 output chained into lane 1
    doReset();
    step(L'(1), 1'b0, 1'b0, "R8");
    cnt = 1;
    while (serOut[1] == 1'b0 && cnt < 4 * W) begin
      logic [L-1:0] b;
      b = '0;
      b[1] = mSh[0][W-1];
      step(b, 1'b0, 1'b0, "R8");
      cnt++;
    end
    chk("R8", cnt, 2 * W);

    // R1: reset in the middle of activity
    for (int j = 0; j < 10; j++) step(word(j + 40), 1'b0, 1'b0, "R5");
    doReset();
    step('0, 1'b0, 1'b0, "R1");
    wait (sbq.size() == 0);
    @(posedge clk);
    finish();
  end
endmodule